// File: doc/BRIEF.md
# Output Fault Sequencer

This block decides, cycle by cycle, whether the regulated supply output may be driven. It watches two digital fault flags from the analog side, an overload detector and an over-temperature detector, together with the current voltage-select code and three policy bits. From these it produces the output enable, the overload and over-temperature status flags, and a request to clear the voltage-select register.

Two overload modes are offered. In pulsed mode a hiccup sequencer lets the output run for an on window, then removes it for a much longer off window, and keeps retrying until one full on window passes with no overload. In static mode the output stays on under the analog clamp and the overload flag just follows the detector. For both overload and heat, a policy bit picks either automatic restart or a sticky shutdown that asks for the voltage select to be cleared. Both window lengths are parameters counted in millisecond ticks.

Top module: `out_guard`

## Requirements
- R1: After reset `olf`, `otf` and `vsel_clr` are 0, and `out_en` is 1 whenever `vsel_in` is non-zero.
- R2: A `vsel_in` of 0000 (standby) always holds `out_en` at 0.
- R3: In pulsed mode (`clamp_static`=0), an overload seen while idle keeps `out_en` at 1 for exactly ON_MS ticks; at the clock edge ending that window `out_en` falls and `olf` rises together.
- R4: The off window lasts exactly OFF_MS ticks, after which `out_en` returns for a retry window of ON_MS ticks; an overload seen during the retry window starts another off window.
- R5: A retry window that ends with no overload seen returns the block to normal and clears `olf` on that edge, with `out_en` staying 1.
- R6: The hiccup windows advance only on clock edges where `tick_ms` is 1; with `tick_ms` held at 0 no window ends and `olf` does not change.
- R7: In static mode (`clamp_static`=1) `out_en` stays 1 through an overload and `olf` equals `ovl_det` as sampled one edge earlier.
- R8: With `ovl_lock_en`=1 a detected overload (static mode) or an off-window entry (pulsed mode) sets `vsel_clr` to 1 and holds `out_en` at 0 even after the overload clears; the request drops one edge after `vsel_in` is seen as 0, and a new non-zero `vsel_in` enables the output again.
- R9: `otf` equals `hot_det` as sampled one edge earlier, `out_en` is 0 while `otf` is 1, and with `hot_lock_en`=0 the output restarts by itself once the heat clears.
- R10: With `hot_lock_en`=1 an over-temperature sets `vsel_clr`, which stays 1 after the heat clears until `vsel_in` is seen as 0.
- R11: While `hot_det` is 1 the hiccup sequencer is held in reset: its counter restarts, `olf` is 0, and an overload still present when the heat clears starts a fresh, full ON_MS window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick_ms | input | 1 | One-cycle pulse per millisecond |
| ovl_det | input | 1 | Overload detected by the analog limiter |
| hot_det | input | 1 | Junction over-temperature detected |
| clamp_static | input | 1 | 1 = static clamp, 0 = pulsed hiccup limiting |
| ovl_lock_en | input | 1 | 1 = overload forces a sticky shutdown and select clear |
| hot_lock_en | input | 1 | 1 = over-temperature forces a sticky shutdown and select clear |
| vsel_in | input | 4 | Current voltage-select code; 0000 is standby |
| out_en | output | 1 | Enable for the regulated output stage |
| olf | output | 1 | Overload status flag |
| otf | output | 1 | Over-temperature status flag |
| vsel_clr | output | 1 | Request to clear the voltage-select register |

## Verification
The properties assume that `tick_ms` is a single-cycle pulse and that every input changes only between clock edges, so that one sample per edge captures it; the bench drives all inputs a quarter period after the rising edge. They also take the policy bits and `clamp_static` as quasi-static during a fault episode, and the bench changes them only with the sequencer idle or across a reset. The mirror and tick-hold properties assume the detectors are not glitching faster than the clock, which the bench respects by holding each level for whole cycles.

// File: rtl/out_guard.sv
module out_guard #(
  parameter int ON_MS  = 90,
  parameter int OFF_MS = 900
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick_ms,
  input  logic       ovl_det,
  input  logic       hot_det,
  input  logic       clamp_static,
  input  logic       ovl_lock_en,
  input  logic       hot_lock_en,
  input  logic [3:0] vsel_in,
  output logic       out_en,
  output logic       olf,
  output logic       otf,
  output logic       vsel_clr
);
  localparam int MAXW = (OFF_MS > ON_MS) ? OFF_MS : ON_MS;
  localparam int CW = $clog2(MAXW + 1);
  localparam logic [CW-1:0] ON_LAST  = CW'(ON_MS - 1);
  localparam logic [CW-1:0] OFF_LAST = CW'(OFF_MS - 1);

  typedef enum logic [1:0] {S_IDLE, S_ON, S_OFF} seq_t;

  seq_t          st;
  logic [CW-1:0] cnt;
  logic          seen;
  logic          olock, hlock;

  wire pulsed  = !hot_det && !clamp_static;
  wire on_end  = pulsed && st == S_ON && tick_ms && cnt == ON_LAST;
  wire go_off  = on_end && (seen || ovl_det);
  wire off_end = pulsed && st == S_OFF && tick_ms && cnt == OFF_LAST;
  wire o_set   = ovl_lock_en && (go_off || (clamp_static && !hot_det && ovl_det));
  wire h_set   = hot_lock_en && hot_det;
  wire vsel_z  = vsel_in == 4'd0;

  assign out_en   = !vsel_z && !otf && !olock && !hlock && st != S_OFF;
  assign vsel_clr = olock || hlock;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st    <= S_IDLE;
      cnt   <= '0;
      seen  <= 1'b0;
      olf   <= 1'b0;
      otf   <= 1'b0;
      olock <= 1'b0;
      hlock <= 1'b0;
    end else begin
      otf <= hot_det;
      if (o_set)       olock <= 1'b1;
      else if (vsel_z) olock <= 1'b0;
      if (h_set)       hlock <= 1'b1;
      else if (vsel_z) hlock <= 1'b0;

      if (hot_det || clamp_static) begin
        st   <= S_IDLE;
        cnt  <= '0;
        seen <= 1'b0;
        olf  <= !hot_det && ovl_det;
      end else begin
        case (st)
          S_IDLE: if (ovl_det) begin
            st   <= S_ON;
            cnt  <= '0;
            seen <= 1'b1;
          end
          S_ON: begin
            seen <= seen || ovl_det;
            if (on_end) begin
              cnt <= '0;
              st  <= go_off ? S_OFF : S_IDLE;
              olf <= go_off;
            end else if (tick_ms) begin
              cnt <= cnt + 1'b1;
            end
          end
          S_OFF: begin
            if (off_end) begin
              st   <= S_ON;
              cnt  <= '0;
              seen <= 1'b0;
            end else if (tick_ms) begin
              cnt <= cnt + 1'b1;
            end
          end
          default: st <= S_IDLE;
        endcase
      end
    end
  end
endmodule

// File: rtl/out_guard_chk.sv
module out_guard_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       tick_ms,
  input logic       ovl_det,
  input logic       hot_det,
  input logic       clamp_static,
  input logic [3:0] vsel_in,
  input logic       out_en,
  input logic       olf,
  input logic       otf,
  input logic       vsel_clr
);
  logic armed;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) armed <= 1'b0;
    else        armed <= 1'b1;

  a_r2_standby_off: assert property (@(posedge clk) disable iff (!rst_n)
    (vsel_in == 4'd0) |-> !out_en);

  a_r9_hot_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    otf |-> !out_en);

  a_r8_clear_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    vsel_clr |-> !out_en);

  a_r7_static_mirror: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && $past(clamp_static) && !$past(hot_det)) |-> (olf == $past(ovl_det)));

  a_r6_tick_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && $past(!clamp_static && !tick_ms && !hot_det)) |-> (olf == $past(olf)));

  a_r3_flag_with_off: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && $past(!clamp_static) && $rose(olf)) |-> !out_en);
endmodule

bind out_guard out_guard_chk u_chk (
  .clk(clk), .rst_n(rst_n), .tick_ms(tick_ms), .ovl_det(ovl_det),
  .hot_det(hot_det), .clamp_static(clamp_static), .vsel_in(vsel_in),
  .out_en(out_en), .olf(olf), .otf(otf), .vsel_clr(vsel_clr)
);

// File: tb/test_out_guard.sv
module test_out_guard;
  localparam int ON_MS  = 4;
  localparam int OFF_MS = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick_ms = 1'b1, ovl_det = 1'b0, hot_det = 1'b0;
  logic clamp_static = 1'b0, ovl_lock_en = 1'b0, hot_lock_en = 1'b0;
  logic [3:0] vsel_in = 4'd0;
  logic out_en, olf, otf, vsel_clr;

  int n_cmp = 0, n_bad = 0;

  always #10 clk = ~clk;

  out_guard #(.ON_MS(ON_MS), .OFF_MS(OFF_MS)) i_out_guard (
    .clk(clk), .rst_n(rst_n), .tick_ms(tick_ms), .ovl_det(ovl_det),
    .hot_det(hot_det), .clamp_static(clamp_static), .ovl_lock_en(ovl_lock_en),
    .hot_lock_en(hot_lock_en), .vsel_in(vsel_in), .out_en(out_en),
    .olf(olf), .otf(otf), .vsel_clr(vsel_clr)
  );

  // {vsel[3:0], ovl, hot, exp_en, exp_olf, exp_otf}, static clamp mode, no locks
  localparam int NV = 8;
  localparam logic [8:0] VEC [NV] = '{
    {4'h5, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0},  // R7 idle
    {4'h5, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0},  // R7 stays on, flag up
    {4'h5, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0},  // R7 flag falls
    {4'h0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0},  // R2 standby
    {4'h0, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0},  // R2 standby under overload
    {4'h8, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1},  // R9 heat shuts off
    {4'h8, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1},  // R11 heat masks overload flag
    {4'h8, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0}   // R9 auto restart
  };

  task automatic cyc(input int n);
    repeat (n) @(posedge clk);
    #5;
  endtask

  task automatic chk(input string tag, input logic [3:0] act, input logic [3:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic do_reset(input logic cs, input logic [3:0] vs);
    rst_n = 1'b0;
    tick_ms = 1'b1; ovl_det = 1'b0; hot_det = 1'b0;
    clamp_static = cs; ovl_lock_en = 1'b0; hot_lock_en = 1'b0;
    vsel_in = vs;
    cyc(3);
    rst_n = 1'b1;
    cyc(1);
  endtask

  initial begin
    #(20 * 200000);
    n_cmp++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    // R1 reset state
    do_reset(1'b0, 4'h3);
    chk("R1 reset {en,olf,otf,clr}", {out_en, olf, otf, vsel_clr}, 4'b1000);

    // table walk, static mode
    do_reset(1'b1, 4'h5);
    for (int i = 0; i < NV; i++) begin
      vsel_in = VEC[i][8:5];
      ovl_det = VEC[i][4];
      hot_det = VEC[i][3];
      cyc(2);
      chk($sformatf("R2 R7 R9 R11 table %0d {en,olf,otf}", i),
          {1'b0, out_en, olf, otf}, {1'b0, VEC[i][2:0]});
    end

    // R3 R4 R5 hiccup sequence
    do_reset(1'b0, 4'h6);
    ovl_det = 1'b1;
    cyc(4);
    chk("R3 on window {en,olf}", {2'b0, out_en, olf}, 4'b0010);
    cyc(1);
    chk("R3 off entry {en,olf}", {2'b0, out_en, olf}, 4'b0001);
    cyc(9);
    chk("R4 off window end {en}", {3'b0, out_en}, 4'b0000);
    cyc(1);
    chk("R4 retry {en,olf}", {2'b0, out_en, olf}, 4'b0011);
    cyc(4);
    chk("R4 repeat off {en,olf}", {2'b0, out_en, olf}, 4'b0001);
    ovl_det = 1'b0;
    cyc(10);
    chk("R4 second retry {en}", {3'b0, out_en}, 4'b0001);
    cyc(3);
    chk("R5 window not done {olf}", {3'b0, olf}, 4'b0001);
    cyc(1);
    chk("R5 clean recovery {en,olf}", {2'b0, out_en, olf}, 4'b0010);

    // R6 tick gating
    do_reset(1'b0, 4'h2);
    tick_ms = 1'b0;
    ovl_det = 1'b1;
    cyc(30);
    chk("R6 no tick holds {en,olf}", {2'b0, out_en, olf}, 4'b0010);
    tick_ms = 1'b1;
    cyc(3);
    chk("R6 ticks resume {en}", {3'b0, out_en}, 4'b0001);
    cyc(1);
    chk("R6 window ends {en,olf}", {2'b0, out_en, olf}, 4'b0001);
    tick_ms = 1'b0;
    cyc(20);
    chk("R6 off held {en}", {3'b0, out_en}, 4'b0000);

    // R8 overload lock, static mode
    do_reset(1'b1, 4'h3);
    ovl_lock_en = 1'b1;
    ovl_det = 1'b1;
    cyc(1);
    chk("R8 lock set {en,olf,clr}", {1'b0, out_en, olf, vsel_clr}, 4'b0011);
    ovl_det = 1'b0;
    cyc(3);
    chk("R8 lock sticky {en,clr}", {2'b0, out_en, vsel_clr}, 4'b0001);
    vsel_in = 4'h0;
    cyc(1);
    chk("R8 lock released {clr}", {3'b0, vsel_clr}, 4'b0000);
    vsel_in = 4'h3;
    cyc(1);
    chk("R8 new select enables {en}", {3'b0, out_en}, 4'b0001);

    // R8 overload lock, pulsed mode
    do_reset(1'b0, 4'h4);
    ovl_lock_en = 1'b1;
    ovl_det = 1'b1;
    cyc(5);
    chk("R8 pulsed lock {en,clr}", {2'b0, out_en, vsel_clr}, 4'b0001);
    ovl_det = 1'b0;
    vsel_in = 4'h0;
    cyc(20);
    chk("R8 pulsed released {clr}", {3'b0, vsel_clr}, 4'b0000);
    vsel_in = 4'h4;
    cyc(1);
    chk("R8 pulsed re-enable {en}", {3'b0, out_en}, 4'b0001);

    // R10 thermal lock
    do_reset(1'b0, 4'h9);
    hot_lock_en = 1'b1;
    hot_det = 1'b1;
    cyc(1);
    chk("R10 heat lock {en,otf,clr}", {1'b0, out_en, otf, vsel_clr}, 4'b0011);
    hot_det = 1'b0;
    cyc(2);
    chk("R10 sticky after cool {en,otf,clr}", {1'b0, out_en, otf, vsel_clr}, 4'b0001);
    vsel_in = 4'h0;
    cyc(1);
    chk("R10 released {clr}", {3'b0, vsel_clr}, 4'b0000);
    vsel_in = 4'h9;
    cyc(1);
    chk("R10 restart {en}", {3'b0, out_en}, 4'b0001);

    // R11 heat priority over hiccup
    do_reset(1'b0, 4'h7);
    ovl_det = 1'b1;
    cyc(3);
    hot_det = 1'b1;
    cyc(20);
    chk("R11 held {en,olf,otf}", {1'b0, out_en, olf, otf}, 4'b0001);
    hot_det = 1'b0;
    cyc(4);
    chk("R11 fresh window {en,olf}", {2'b0, out_en, olf}, 4'b0010);
    cyc(1);
    chk("R11 window end {en,olf}", {2'b0, out_en, olf}, 4'b0001);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule